// File: doc/BRIEF.md
# PCI Target Claim and DEVSEL Decoder

This block watches the address phase of a conventional 32-bit PCI bus and decides whether the local device answers the transaction. When it answers, it drives DEVSEL# through a separate output enable and raises a claim strobe for one clock. It also reports a command class. For configuration accesses it reports the register and function numbers taken from the address bus. Data-phase handling, parity and the master side live elsewhere. The TRDY# that the local data-phase logic drives comes back in only to mark the final data phase.

Memory commands are claimed through a base/mask window. Configuration commands are claimed only in satellite mode, and only as Type 0 with IDSEL high. The block never claims I/O, Special Cycle, Interrupt Acknowledge, Dual Address Cycle or reserved commands. Reads always use fast decode. Writes use fast decode unless the parity-error-enable input is set, in which case they use medium decode. A separate combinational flag tells whether the cacheline-size value is one of the two supported sizes.

Top module: `pci_claim_decode`

## Requirements
- R1: After reset, devsel_n is 1, devsel_oe is 0, claim is 0 and cmd_class is 0.
- R2: An address phase is the first rising edge with frame_n low after an edge with frame_n high. At that edge, a Memory Read (C/BE# 0110), Memory Read Multiple (1100) or Memory Read Line (1110) with (ad & bar_mask) == bar_base is claimed with cmd_class 1. A Memory Write (0111) with the same address match is claimed with cmd_class 2. A command whose address misses the window is not claimed.
- R3: Reads (cmd_class 1 or 3), and writes while perr_en is 0, use fast decode. In the clock after the address edge, claim is 1, devsel_n is 0 and devsel_oe is 1.
- R4: Writes (cmd_class 2 or 4) while perr_en is 1 use medium decode. In the clock after the address edge, claim is 1 and devsel_n is 1 with devsel_oe 0. devsel_n goes to 0, with devsel_oe 1, one clock later.
- R5: Interrupt Acknowledge (0000), Special Cycle (0001), I/O Read (0010), I/O Write (0011), Dual Address Cycle (1101) and the reserved codes (0100, 0101, 1000, 1001) are never claimed. For these, devsel_oe stays 0.
- R6: In satellite mode (host_mode 0), a Configuration Read (1010) or Configuration Write (1011) with idsel 1 and ad[1:0] = 00 is claimed. The class is 3 for a read and 4 for a write. cfg_reg takes ad[7:2] and cfg_fn takes ad[10:8].
- R7: A configuration command is not claimed when ad[1:0] is not 00 (Type 1), when idsel is 0, or when host_mode is 1.
- R8: Memory Write and Invalidate (1111) is handled as a plain Memory Write: it is claimed on an address match with cmd_class 2.
- R9: An edge with devsel asserted and frame_n high, irdy_n low and trdy_n low marks the final data phase. In the next clock devsel_n is 1 while devsel_oe is still 1. devsel_oe is 0 one clock after that.
- R10: An address phase that falls on the turnaround clock of R9 is decoded. On a fast claim, devsel_oe stays 1 and devsel_n returns to 0 in the next clock.
- R11: line_size_ok is 1 exactly when line_size is 4 or 8.
- R12: claim is high for a single clock per claimed transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | Active-low reset |
| frame_n | input | 1 | FRAME# from the bus |
| irdy_n | input | 1 | IRDY# from the bus |
| trdy_n | input | 1 | TRDY# as driven by the local data-phase logic |
| idsel | input | 1 | Configuration select |
| ad | input | 32 | Address/data bus |
| cbe_n | input | 4 | Command / byte enables |
| host_mode | input | 1 | 1 = host, 0 = satellite |
| perr_en | input | 1 | Parity-error-enable bit |
| bar_base | input | 32 | Memory window base |
| bar_mask | input | 32 | Memory window mask |
| line_size | input | 8 | Cacheline-size register value |
| devsel_n | output | 1 | DEVSEL# output value |
| devsel_oe | output | 1 | DEVSEL# output enable |
| claim | output | 1 | One-clock strobe on a claimed address phase |
| cmd_class | output | 3 | 0 none, 1 mem read, 2 mem write, 3 cfg read, 4 cfg write |
| cfg_reg | output | 6 | Configuration register number |
| cfg_fn | output | 3 | Configuration function number |
| line_size_ok | output | 1 | Cacheline size is supported |

## Verification
The end of one transaction and the decode of the next can fall in the same clock. The turnaround clock, in which devsel_n has just been parked high and devsel_oe is still set, can also be an address phase under fast back-to-back timing. The bench provokes this by lowering frame_n right after the final data phase. It judges the result at the ports. With a fast claim, devsel_oe must never drop and devsel_n must return low. With a medium claim, the output enable must be released for one clock before DEVSEL# is asserted.

// File: rtl/pci_claim_decode.sv
module pci_claim_decode #(
  parameter int AD_W  = 32,
  parameter int CBE_W = 4,
  parameter int LS_W  = 8,
  parameter int CLS_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_n,
  input  logic              irdy_n,
  input  logic              trdy_n,
  input  logic              idsel,
  input  logic [AD_W-1:0]   ad,
  input  logic [CBE_W-1:0]  cbe_n,
  input  logic              host_mode,
  input  logic              perr_en,
  input  logic [AD_W-1:0]   bar_base,
  input  logic [AD_W-1:0]   bar_mask,
  input  logic [LS_W-1:0]   line_size,
  output logic              devsel_n,
  output logic              devsel_oe,
  output logic              claim,
  output logic [CLS_W-1:0]  cmd_class,
  output logic [5:0]        cfg_reg,
  output logic [2:0]        cfg_fn
  ,output logic             line_size_ok
);
  localparam logic [CLS_W-1:0] C_NONE = CLS_W'(0);
  localparam logic [CLS_W-1:0] C_MRD  = CLS_W'(1);
  localparam logic [CLS_W-1:0] C_MWR  = CLS_W'(2);
  localparam logic [CLS_W-1:0] C_CRD  = CLS_W'(3);
  localparam logic [CLS_W-1:0] C_CWR  = CLS_W'(4);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_ACT, S_TURN} st_t;

  st_t              st;
  logic             frame_q;
  logic [CLS_W-1:0] raw_cls;
  logic             hit, slow;

  wire addr_ph  = !frame_n && frame_q && (st == S_IDLE || st == S_TURN);
  wire last_ph  = frame_n && !irdy_n && !trdy_n;
  wire mem_hit  = (ad & bar_mask) == bar_base;
  wire cfg_hit  = !host_mode && idsel && (ad[1:0] == 2'b00);

  assign line_size_ok = (line_size == LS_W'(4)) || (line_size == LS_W'(8));

  always_comb begin
    case (cbe_n)
      4'h6, 4'hC, 4'hE: raw_cls = C_MRD;
      4'h7, 4'hF:       raw_cls = C_MWR;
      4'hA:             raw_cls = C_CRD;
      4'hB:             raw_cls = C_CWR;
      default:          raw_cls = C_NONE;
    endcase
    hit  = ((raw_cls == C_MRD || raw_cls == C_MWR) && mem_hit) ||
           ((raw_cls == C_CRD || raw_cls == C_CWR) && cfg_hit);
    slow = perr_en && (raw_cls == C_MWR || raw_cls == C_CWR);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      frame_q   <= 1'b1;
      devsel_n  <= 1'b1;
      devsel_oe <= 1'b0;
      claim     <= 1'b0;
      cmd_class <= C_NONE;
      cfg_reg   <= '0;
      cfg_fn    <= '0;
    end else begin
      frame_q <= frame_n;
      claim   <= 1'b0;
      case (st)
        S_IDLE, S_TURN: begin
          if (addr_ph && hit) begin
            claim     <= 1'b1;
            cmd_class <= raw_cls;
            cfg_reg   <= ad[7:2];
            cfg_fn    <= ad[10:8];
            if (slow) begin
              st        <= S_WAIT;
              devsel_n  <= 1'b1;
              devsel_oe <= 1'b0;
            end else begin
              st        <= S_ACT;
              devsel_n  <= 1'b0;
              devsel_oe <= 1'b1;
            end
          end else begin
            st        <= S_IDLE;
            devsel_n  <= 1'b1;
            devsel_oe <= 1'b0;
          end
        end
        S_WAIT: begin
          st        <= S_ACT;
          devsel_n  <= 1'b0;
          devsel_oe <= 1'b1;
        end
        S_ACT: begin
          if (last_ph) begin
            st       <= S_TURN;
            devsel_n <= 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module pci_claim_decode_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        frame_n,
  input logic [31:0] ad,
  input logic [3:0]  cbe_n,
  input logic        perr_en,
  input logic        devsel_n,
  input logic        devsel_oe,
  input logic        claim,
  input logic [2:0]  cmd_class
);
  p_oe_when_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !devsel_n |-> devsel_oe);
  p_park_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(devsel_oe) |-> $past(devsel_n));
  p_claim_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    claim |=> !claim);
  p_fast_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (claim && (cmd_class == 3'd1 || cmd_class == 3'd3)) |-> !devsel_n);
  p_fast_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (claim && (cmd_class == 3'd2 || cmd_class == 3'd4) && !$past(perr_en)) |-> !devsel_n);
  p_medium_late_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (claim && (cmd_class == 3'd2 || cmd_class == 3'd4) && $past(perr_en)) |-> devsel_n);
  p_medium_then_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (claim && (cmd_class == 3'd2 || cmd_class == 3'd4) && $past(perr_en)) |=> !devsel_n);
  p_no_io_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(frame_n) && (cbe_n inside {4'h0, 4'h1, 4'h2, 4'h3, 4'hD})) |=> !claim);
  p_no_type1_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(frame_n) && cbe_n[3:1] == 3'b101 && ad[1:0] != 2'b00) |=> !claim);
endmodule

bind pci_claim_decode pci_claim_decode_chk u_chk (
  .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .ad(ad), .cbe_n(cbe_n),
  .perr_en(perr_en), .devsel_n(devsel_n), .devsel_oe(devsel_oe),
  .claim(claim), .cmd_class(cmd_class)
);

// File: tb/pci_claim_decode_bench.sv
module pci_claim_decode_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_n = 1'b1, irdy_n = 1'b1, trdy_n = 1'b1, idsel = 1'b0;
  logic [31:0] ad = '0;
  logic [3:0]  cbe_n = 4'hF;
  logic host_mode = 1'b0, perr_en = 1'b0;
  logic [31:0] bar_base = 32'h8000_0000, bar_mask = 32'hF000_0000;
  logic [7:0]  line_size = 8'd0;
  logic devsel_n, devsel_oe, claim, line_size_ok;
  logic [2:0] cmd_class;
  logic [5:0] cfg_reg;
  logic [2:0] cfg_fn;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pci_claim_decode u_pci_claim_decode (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n), .trdy_n(trdy_n),
    .idsel(idsel), .ad(ad), .cbe_n(cbe_n), .host_mode(host_mode), .perr_en(perr_en),
    .bar_base(bar_base), .bar_mask(bar_mask), .line_size(line_size),
    .devsel_n(devsel_n), .devsel_oe(devsel_oe), .claim(claim), .cmd_class(cmd_class),
    .cfg_reg(cfg_reg), .cfg_fn(cfg_fn), .line_size_ok(line_size_ok)
  );

  typedef struct packed {
    logic [3:0]  cmd;
    logic [31:0] addr;
    logic        sel;
    logic        host;
    logic        perr;
    logic        hit;
    logic [2:0]  cls;
    logic        med;
    logic [5:0]  rg;
    logic [2:0]  fn;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VEC [NV] = '{
    '{4'h6, 32'h8000_1000, 1'b0, 1'b0, 1'b1, 1'b1, 3'd1, 1'b0, 6'd0, 3'd0},  // R2 R3 read fast with perr
    '{4'h7, 32'h8000_2000, 1'b0, 1'b0, 1'b0, 1'b1, 3'd2, 1'b0, 6'd0, 3'd0},  // R3 write fast
    '{4'h7, 32'h8123_4564, 1'b0, 1'b0, 1'b1, 1'b1, 3'd2, 1'b1, 6'd0, 3'd0},  // R4 write medium
    '{4'h6, 32'h9000_0000, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 6'd0, 3'd0},  // R2 miss
    '{4'hE, 32'h8FFF_FFFC, 1'b0, 1'b0, 1'b1, 1'b1, 3'd1, 1'b0, 6'd0, 3'd0},  // R2 read line
    '{4'hC, 32'h8000_0040, 1'b0, 1'b0, 1'b0, 1'b1, 3'd1, 1'b0, 6'd0, 3'd0},  // R2 read multiple
    '{4'hF, 32'h8000_0080, 1'b0, 1'b0, 1'b0, 1'b1, 3'd2, 1'b0, 6'd0, 3'd0},  // R8 MWI
    '{4'h2, 32'h8000_0000, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 6'd0, 3'd0},  // R5 io read
    '{4'h3, 32'h8000_0000, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 6'd0, 3'd0},  // R5 io write
    '{4'h1, 32'h8000_0000, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 6'd0, 3'd0},  // R5 special
    '{4'hD, 32'h8000_0000, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 6'd0, 3'd0},  // R5 dual address
    '{4'h0, 32'h8000_0000, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 6'd0, 3'd0},  // R5 int ack
    '{4'h4, 32'h8000_0000, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 6'd0, 3'd0},  // R5 reserved
    '{4'hA, 32'h0000_0534, 1'b1, 1'b0, 1'b1, 1'b1, 3'd3, 1'b0, 6'd13, 3'd5}, // R6 cfg read
    '{4'hB, 32'h0000_0208, 1'b1, 1'b0, 1'b1, 1'b1, 3'd4, 1'b1, 6'd2, 3'd2},  // R6 cfg write medium
    '{4'hB, 32'h0000_07FC, 1'b1, 1'b0, 1'b0, 1'b1, 3'd4, 1'b0, 6'd63, 3'd7}, // R6 cfg write fast
    '{4'hA, 32'h0000_0535, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 6'd0, 3'd0},  // R7 type 1
    '{4'hA, 32'h0000_0534, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 6'd0, 3'd0},  // R7 idsel low
    '{4'hA, 32'h0000_0534, 1'b1, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0, 6'd0, 3'd0}   // R7 host mode
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic addr_phase(input logic [3:0] c, input logic [31:0] a, input logic s);
    frame_n = 1'b0; irdy_n = 1'b1; trdy_n = 1'b1;
    cbe_n = c; ad = a; idsel = s;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic last_phase;
    frame_n = 1'b1; irdy_n = 1'b0; trdy_n = 1'b0; idsel = 1'b0;
  endtask

  task automatic idle(input int n);
    frame_n = 1'b1; irdy_n = 1'b1; trdy_n = 1'b1;
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: actual %0h expected %0h", 0, 1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(devsel_n === 1'b1, "R1 devsel_n", 32'(devsel_n), 1);
    chk(devsel_oe === 1'b0, "R1 devsel_oe", 32'(devsel_oe), 0);
    chk(claim === 1'b0, "R1 claim", 32'(claim), 0);
    chk(cmd_class === 3'd0, "R1 cmd_class", 32'(cmd_class), 0);
    rst_n = 1'b1;
    idle(2);

    for (int i = 0; i < NV; i++) begin
      host_mode = VEC[i].host;
      perr_en   = VEC[i].perr;
      addr_phase(VEC[i].cmd, VEC[i].addr, VEC[i].sel);
      chk(claim === VEC[i].hit, $sformatf("R2/R5/R7 claim v%0d", i), 32'(claim), 32'(VEC[i].hit));
      if (VEC[i].hit) begin
        chk(cmd_class === VEC[i].cls, $sformatf("R2/R6/R8 class v%0d", i), 32'(cmd_class), 32'(VEC[i].cls));
        if (VEC[i].cls >= 3'd3) begin
          chk(cfg_reg === VEC[i].rg, $sformatf("R6 reg v%0d", i), 32'(cfg_reg), 32'(VEC[i].rg));
          chk(cfg_fn === VEC[i].fn, $sformatf("R6 fn v%0d", i), 32'(cfg_fn), 32'(VEC[i].fn));
        end
        if (VEC[i].med) begin
          chk(devsel_n === 1'b1 && devsel_oe === 1'b0, $sformatf("R4 late v%0d", i),
              {devsel_n, devsel_oe}, 32'h2);
        end else begin
          chk(devsel_n === 1'b0 && devsel_oe === 1'b1, $sformatf("R3 fast v%0d", i),
              {devsel_n, devsel_oe}, 32'h1);
        end
      end else begin
        chk(devsel_oe === 1'b0, $sformatf("R5/R7 oe v%0d", i), 32'(devsel_oe), 0);
      end
      last_phase();
      @(negedge clk);
      if (VEC[i].hit && VEC[i].med) begin
        chk(devsel_n === 1'b0 && devsel_oe === 1'b1, $sformatf("R4 asserted v%0d", i),
            {devsel_n, devsel_oe}, 32'h1);
        chk(claim === 1'b0, $sformatf("R12 pulse v%0d", i), 32'(claim), 0);
        @(negedge clk);
      end
      if (VEC[i].hit) begin
        chk(devsel_n === 1'b1 && devsel_oe === 1'b1, $sformatf("R9 park v%0d", i),
            {devsel_n, devsel_oe}, 32'h3);
      end
      idle(1);
      chk(devsel_oe === 1'b0 && devsel_n === 1'b1, $sformatf("R9 release v%0d", i),
          {devsel_n, devsel_oe}, 32'h2);
      idle(1);
    end

    // R10 fast back-to-back into the turnaround clock
    host_mode = 1'b0; perr_en = 1'b0;
    addr_phase(4'h7, 32'h8000_0100, 1'b0);
    last_phase();
    @(negedge clk);
    chk(devsel_n === 1'b1 && devsel_oe === 1'b1, "R10 turnaround", {devsel_n, devsel_oe}, 32'h3);
    addr_phase(4'h6, 32'h8000_0200, 1'b0);
    chk(claim === 1'b1, "R10 claim", 32'(claim), 1);
    chk(devsel_n === 1'b0 && devsel_oe === 1'b1, "R10 fast keep oe", {devsel_n, devsel_oe}, 32'h1);
    last_phase();
    @(negedge clk);
    // R10 medium write in the turnaround clock
    perr_en = 1'b1;
    addr_phase(4'h7, 32'h8000_0300, 1'b0);
    chk(claim === 1'b1, "R10 medium claim", 32'(claim), 1);
    chk(devsel_n === 1'b1 && devsel_oe === 1'b0, "R10 medium release", {devsel_n, devsel_oe}, 32'h2);
    last_phase();
    @(negedge clk);
    chk(devsel_n === 1'b0 && devsel_oe === 1'b1, "R10 medium assert", {devsel_n, devsel_oe}, 32'h1);
    @(negedge clk);
    idle(3);
    chk(devsel_oe === 1'b0, "R9 idle after b2b", 32'(devsel_oe), 0);

    // R11 cacheline size
    for (int v = 0; v < 20; v++) begin
      line_size = 8'(v);
      #1;
      chk(line_size_ok === ((v == 4) || (v == 8)), $sformatf("R11 size %0d", v),
          32'(line_size_ok), 32'((v == 4) || (v == 8)));
    end
    line_size = 8'd255; #1;
    chk(line_size_ok === 1'b0, "R11 size 255", 32'(line_size_ok), 0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule